// File: doc/BRIEF.md
# Exact-width signed/unsigned adder

This block adds two N-bit operands and returns an (N+1)-bit result that is always exact. A one-bit mode input chooses how the operands are read. When it is low, both operands are unsigned. When it is high, both are two's-complement values. The block is purely combinational, with no clock and no state. A signed-overflow flag reports whether the low N bits alone would have overflowed as a signed result.

The sum comes from a ripple chain of exactly N full-adder stages, and the chain's carry in is tied to zero. The top result bit is not produced by a sign-extended (N+1)th stage. In unsigned mode it is the chain's final carry. In signed mode a small selector picks it: it takes the final carry when the N-bit result overflowed, and a copy of sum bit N-1 when it did not. The width parameter defaults to 8.

Top module: `wide_adder`

## Requirements
- R1: With `is_signed` = 0, `sum` equals both operands zero-extended to N+1 bits and added, so `sum[N]` is the carry out of the last stage.
- R2: With `is_signed` = 1, `sum` equals both operands sign-extended to N+1 bits and added, modulo 2^(N+1).
- R3: With `is_signed` = 1 and `ovf` = 1, `sum[N]` equals the carry out of the last stage, which is the shared sign bit of the operands and the inverse of `sum[N-1]`.
- R4: With `is_signed` = 1 and `ovf` = 0, `sum[N]` equals `sum[N-1]`.
- R5: In both modes, `ovf` is 1 exactly when the N-bit two's-complement sum of the operands falls outside the range -2^(N-1) to 2^(N-1)-1.
- R6: In both modes, `sum[N-1:0]` equals (a + b) mod 2^N.
- R7: With N = 6 and `is_signed` = 1, 101011 + 000000 gives 1101011, and 101011 + 100000 gives 1001011.
- R8: The outputs depend only on the present inputs, with no clock or held state. A new input pattern shows its result within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned operands |
| sum | output | N+1 | Exact sum |
| ovf | output | 1 | Signed overflow of the N-bit result |

## Verification
A wrong carry anywhere in the chain shows up as a corrupted `sum` bit, and often as a wrong `ovf`, on the same input pattern that exposes it. There is no state, so nothing can hide an error for later cycles. A faulty top-bit selector shows only in signed mode, in the overflow case or the no-overflow case. Because of this, every operand pair is applied in both modes at N = 4 and N = 6, and each pair is checked in the cycle it is applied.

// File: rtl/wide_adder.sv
module wide_adder #(
  parameter int N = 8
) (
  input  logic [N-1:0] a,
  input  logic [N-1:0] b,
  input  logic         is_signed,
  output logic [N:0]   sum,
  output logic         ovf
);

  localparam int MSB = N - 1;

  logic [N:0]   carry;
  logic [MSB:0] s;
  logic         top;

  assign carry[0] = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_stage
    logic p;
    assign p          = a[k] ^ b[k];
    assign s[k]       = p ^ carry[k];
    assign carry[k+1] = (a[k] & b[k]) | (p & carry[k]);
  end

  assign ovf = carry[N] ^ carry[MSB];
  assign top = is_signed ? (ovf ? carry[N] : s[MSB]) : carry[N];
  assign sum = {top, s};

endmodule

module wide_adder_chk #(
  parameter int N = 8
) (
  input logic [N-1:0] a,
  input logic [N-1:0] b,
  input logic         is_signed,
  input logic [N:0]   sum,
  input logic         ovf
);

  logic [N:0] zx_sum;
  logic [N:0] sx_sum;
  logic       sg_ovf;

  always_comb begin
    zx_sum = {1'b0, a} + {1'b0, b};
    sx_sum = {a[N-1], a} + {b[N-1], b};
    sg_ovf = (a[N-1] == b[N-1]) && (sx_sum[N-1] != a[N-1]);
    if (!$isunknown({a, b, is_signed, sum, ovf})) begin
      if (!is_signed)
        p_unsigned_exact_r1: assert (sum == zx_sum) else $error("R1 unsigned sum");
      if (is_signed)
        p_signed_exact_r2: assert (sum == sx_sum) else $error("R2 signed sum");
      if (is_signed && ovf)
        p_top_on_overflow_r3: assert (sum[N] == a[N-1] && sum[N] != sum[N-1]) else $error("R3 top bit");
      if (is_signed && !ovf)
        p_top_no_overflow_r4: assert (sum[N] == sum[N-1]) else $error("R4 top bit");
      p_overflow_flag_r5: assert (ovf == sg_ovf) else $error("R5 overflow flag");
      p_low_bits_r6: assert (sum[N-1:0] == zx_sum[N-1:0]) else $error("R6 low bits");
    end
  end

endmodule

bind wide_adder wide_adder_chk #(.N(N)) u_wide_adder_chk (
  .a(a), .b(b), .is_signed(is_signed), .sum(sum), .ovf(ovf)
);

// File: tb/test_wide_adder.sv
`timescale 1ns/1ps
module test_wide_adder;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [5:0] a6, b6;
  logic [3:0] a4, b4;
  logic [7:0] a8, b8;
  logic       sg;
  logic [6:0] sum6;
  logic [4:0] sum4;
  logic [8:0] sum8;
  logic       ovf6, ovf4, ovf8;

  wide_adder #(.N(6)) i_wide_adder    (.a(a6), .b(b6), .is_signed(sg), .sum(sum6), .ovf(ovf6));
  wide_adder #(.N(4)) i_wide_adder_n4 (.a(a4), .b(b4), .is_signed(sg), .sum(sum4), .ovf(ovf4));
  wide_adder          i_wide_adder_n8 (.a(a8), .b(b8), .is_signed(sg), .sum(sum8), .ovf(ovf8));

  task automatic chk(input string tag, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int as_val(int n, int v, bit s);
    if (s && ((v >> (n - 1)) & 1) == 1) return v - (1 << n);
    return v;
  endfunction

  task automatic check_width(input int n, input int av, input int bv, input bit s,
                             input int got_sum, input int got_ovf);
    int ref_sum, sa, sb, lo, hi, top, below;
    bit ref_ovf;
    ref_sum = (as_val(n, av, s) + as_val(n, bv, s)) & ((1 << (n + 1)) - 1);
    sa = as_val(n, av, 1'b1);
    sb = as_val(n, bv, 1'b1);
    lo = -(1 << (n - 1));
    hi = (1 << (n - 1)) - 1;
    ref_ovf = (sa + sb > hi) || (sa + sb < lo);
    chk(s ? "R2 signed sum" : "R1 unsigned sum", got_sum, ref_sum);
    chk("R5 overflow flag", got_ovf, int'(ref_ovf));
    chk("R6 low bits", got_sum & ((1 << n) - 1), (av + bv) & ((1 << n) - 1));
    if (s) begin
      top   = (got_sum >> n) & 1;
      below = (got_sum >> (n - 1)) & 1;
      if (ref_ovf) chk("R3 top bit on overflow", top, (av >> (n - 1)) & 1);
      else         chk("R4 top bit copies msb", top, below);
    end
  endtask

  initial begin
    a6 = '0; b6 = '0; a4 = '0; b4 = '0; a8 = '0; b8 = '0; sg = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 zero inputs sum", int'(sum6), 0);
    chk("R8 zero inputs ovf", int'(ovf6), 0);

    sg = 1'b1; a6 = 6'b101011; b6 = 6'b000000;
    @(negedge clk);
    chk("R7 101011+000000", int'(sum6), 7'b1101011);
    a6 = 6'b101011; b6 = 6'b100000;
    @(negedge clk);
    chk("R7 101011+100000", int'(sum6), 7'b1001011);
    chk("R7 overflow flagged", int'(ovf6), 1);

    for (int i = 0; i < 8192; i++) begin
      @(posedge clk);
      #1;
      sg = i[12];
      a6 = i[11:6]; b6 = i[5:0];
      a4 = i[7:4];  b4 = i[3:0];
      a8 = 8'(i * 37); b8 = 8'(i * 91 + 5);
      @(negedge clk);
      check_width(6, int'(a6), int'(b6), sg, int'(sum6), int'(ovf6));
      if (i[11:8] == 4'd0) check_width(4, int'(a4), int'(b4), sg, int'(sum4), int'(ovf4));
      check_width(8, int'(a8), int'(b8), sg, int'(sum8), int'(ovf8));
    end

    sg = 1'b0; a6 = 6'h3f; b6 = 6'h01;
    #1;
    chk("R8 same-cycle update", int'(sum6), 64);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule